// File: doc/BRIEF.md
# Program Fetch Source and Read Strobe Controller

This block sits beside a CPU core and decides, for every instruction fetch, whether the code byte is served by on-chip program memory or by an external program memory. When the fetch goes off-chip, it drives the active-low external program read strobe. It also produces the machine-cycle phase that the rest of the core uses for timing. One machine cycle lasts twelve oscillator periods. A divide-by-two toggle stage feeds a six-state counter, so that the state and the toggle bit together form a phase count from 0 to 11.

Each machine cycle has two fetch slots, one in each half. The source decision is made again as each half begins. A fetch goes external if the effective access input is low. It also goes external if that input is high and the program counter lies above the on-chip limit selected by the memory-size code. The largest size setting covers the whole address space, so every fetch is internal in that case. When the security-lock bit is set, the block uses the value of the access pin captured during reset instead of the live pin. A flag marking an external data cycle is sampled as each machine cycle begins. When the flag is set, both strobe pulses of that machine cycle are suppressed.

Top module: `fetch_ctrl`

## Requirements
- R1: While `rst` is high, `strobe_n` is 1, `phase` is 0 and `cycle_start` is 1.
- R2: After reset is released, `phase` advances by one on every clock, from 0 through 11, and then wraps to 0. `cycle_start` is 1 exactly when `phase` is 0. `half_sel` is 1 exactly when `phase` is 6 to 11.
- R3: During an external fetch in a cycle that is not an external data cycle, `strobe_n` is 0 exactly in phases 1–4 for the first-half fetch and in phases 7–10 for the second-half fetch. It is 1 in every other phase.
- R4: `xdata_cycle` is sampled on the clock edge that enters phase 0 and is held for that machine cycle. If it is sampled as 1, `strobe_n` stays 1 for all twelve phases of that cycle, even for external fetches.
- R5: For any fetch served internally (`fetch_ext` = 0), `strobe_n` stays 1.
- R6: When the effective access input is 0, `fetch_ext` is 1 for every address, including 0000H.
- R7: When the effective access input is 1, `fetch_ext` is 1 exactly when `pc` exceeds the on-chip limit. The limit is 1FFFH for `mem_size` 0, 3FFFH for 1 and 7FFFH for 2.
- R8: With `mem_size` 3 and the effective access input at 1, `fetch_ext` is 0 for every address, including FFFFH.
- R9: When `sec_lock` is 1, the effective access input is the value of `ext_access` on the last clock edge of reset. Later changes of `ext_access` have no effect on `fetch_ext`. When `sec_lock` is 0, the live pin is used.
- R10: `pc`, `mem_size` and the access input are sampled only on the clock edges that enter phase 0 and phase 6. `fetch_ext` holds its value for phases 0–5 and for phases 6–11, even if `pc` changes during a half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, one period per phase |
| rst | input | 1 | Synchronous reset, active high |
| ext_access | input | 1 | External-access pin, low forces external fetches |
| sec_lock | input | 1 | Security lock: use the access pin value captured at reset |
| pc | input | 16 | Program counter of the pending fetch |
| mem_size | input | 2 | On-chip size code: 0=8K, 1=16K, 2=32K, 3=64K |
| xdata_cycle | input | 1 | Current machine cycle accesses external data memory |
| fetch_ext | output | 1 | 1 = current fetch served externally, 0 = internally |
| strobe_n | output | 1 | Active-low external program read strobe |
| phase | output | 4 | Oscillator-period phase within the machine cycle, 0 to 11 |
| cycle_start | output | 1 | High in phase 0 |
| half_sel | output | 1 | High in the second half of the machine cycle (phases 6 to 11) |

## Verification
A phase counter that skips or stalls would shift the strobe windows and the `cycle_start` mark against the expected sequence, and the error would be visible within one twelve-clock cycle. A wrong size limit or a bad access-latch value would show up as a wrong `fetch_ext` at the first fetch slot after the decision edge, and the strobe would also appear or disappear in the next phase. An external data flag that is held in the wrong state would let a pulse through, or suppress one, in phase 1 or phase 7 of the affected cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int CYCLE_LEN   = 12;
    localparam int HALF_LEN    = CYCLE_LEN / 2;
    localparam int PHASE_W     = $clog2(CYCLE_LEN);
    localparam int PULSE_START = 1;
    localparam int PULSE_LEN   = 4;

    typedef logic [PHASE_W-1:0] phase_t;

    // true when a phase lies inside the strobe window of either half
    function automatic logic in_window(phase_t p);
        phase_t off;
        off = (p >= phase_t'(HALF_LEN)) ? p - phase_t'(HALF_LEN) : p;
        return (off >= phase_t'(PULSE_START)) &&
               (off <  phase_t'(PULSE_START + PULSE_LEN));
    endfunction
endpackage

// File: rtl/fetch_phase_gen.sv
module fetch_phase_gen
    import fetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase_nxt,
    output phase_t phase,
    output logic   cycle_start,
    output logic   half_sel
);
    localparam int STATES  = CYCLE_LEN / 2;
    localparam int STATE_W = PHASE_W - 1;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               half;
        logic               start;
        logic               second;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d = tim_q;
        if (rst) begin
            tim_d.state = '0;
            tim_d.half  = 1'b0;
        end else begin
            tim_d.half = ~tim_q.half;
            if (tim_q.half) begin
                if (tim_q.state == STATE_W'(STATES - 1))
                    tim_d.state = '0;
                else
                    tim_d.state = tim_q.state + 1'b1;
            end
        end
        tim_d.start  = ({tim_d.state, tim_d.half} == phase_t'(0));
        tim_d.second = ({tim_d.state, tim_d.half} >= phase_t'(HALF_LEN));
    end

    always_ff @(posedge clk) begin
        tim_q <= tim_d;
    end

    assign phase_nxt   = {tim_d.state, tim_d.half};
    assign phase       = {tim_q.state, tim_q.half};
    assign cycle_start = tim_q.start;
    assign half_sel    = tim_q.second;

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        phase == phase_t'(CYCLE_LEN - 1) |=> phase == phase_t'(0));
    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        phase != phase_t'(CYCLE_LEN - 1) |=> phase == $past(phase) + 1'b1);
    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst |=> phase == phase_t'(0) && cycle_start);
endmodule

// File: rtl/fetch_source_sel.sv
module fetch_source_sel
    import fetch_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SIZE_W   = 2,
    parameter int MIN_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              sec_lock,
    input  logic [ADDR_W-1:0] pc,
    input  logic [SIZE_W-1:0] mem_size,
    input  phase_t            phase_nxt,
    output logic              ext_nxt,
    output logic              fetch_ext
);
    typedef struct packed {
        logic pin_latch;
        logic ext;
    } src_t;

    src_t src_d, src_q;
    logic              decide;
    logic              eff_pin;
    logic [ADDR_W:0]   limit;
    logic              beyond;

    always_comb begin
        src_d   = src_q;
        decide  = rst || (phase_nxt == phase_t'(0)) ||
                  (phase_nxt == phase_t'(HALF_LEN));
        eff_pin = (sec_lock && !rst) ? src_q.pin_latch : ext_pin;
        limit   = ({{ADDR_W{1'b0}}, 1'b1} << (MIN_LOG2 + 32'(mem_size))) - 1'b1;
        beyond  = {1'b0, pc} > limit;
        if (rst)
            src_d.pin_latch = ext_pin;
        if (decide)
            src_d.ext = !eff_pin || beyond;
    end

    always_ff @(posedge clk) begin
        src_q <= src_d;
    end

    assign ext_nxt   = src_d.ext;
    assign fetch_ext = src_q.ext;

    // R6
    pin_low_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (decide && !sec_lock && !ext_pin) |=> fetch_ext);
    // R8
    full_int_chk: assert property (@(posedge clk) disable iff (rst)
        (decide && !sec_lock && ext_pin && mem_size == SIZE_W'(3)) |=> !fetch_ext);
    // R9
    lock_low_chk: assert property (@(posedge clk) disable iff (rst)
        (decide && sec_lock && !src_q.pin_latch) |=> fetch_ext);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !decide |=> $stable(fetch_ext));
endmodule

// File: rtl/fetch_strobe_gen.sv
module fetch_strobe_gen
    import fetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_nxt,
    input  logic   ext_nxt,
    input  logic   xdata_cycle,
    input  phase_t phase,
    input  logic   fetch_ext,
    output logic   strobe_n
);
    typedef struct packed {
        logic xdata;
        logic strobe_n;
    } stb_t;

    stb_t stb_d, stb_q;

    always_comb begin
        stb_d = stb_q;
        if (rst)
            stb_d.xdata = 1'b0;
        else if (phase_nxt == phase_t'(0))
            stb_d.xdata = xdata_cycle;
        stb_d.strobe_n = !(!rst && ext_nxt && !stb_d.xdata && in_window(phase_nxt));
    end

    always_ff @(posedge clk) begin
        stb_q <= stb_d;
    end

    assign strobe_n = stb_q.strobe_n;

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> strobe_n);
    // R5
    int_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ext |-> strobe_n);
    // R4
    xdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stb_q.xdata |-> strobe_n);
    // R3
    window_chk: assert property (@(posedge clk) disable iff (rst)
        !in_window(phase) |-> strobe_n);
    // R3
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_ext && !stb_q.xdata && in_window(phase)) |-> !strobe_n);
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SIZE_W   = 2,
    parameter int MIN_LOG2 = 13
) (
    input  logic              clk_osc,
    input  logic              rst,
    input  logic              ext_access,
    input  logic              sec_lock,
    input  logic [ADDR_W-1:0] pc,
    input  logic [SIZE_W-1:0] mem_size,
    input  logic              xdata_cycle,
    output logic              fetch_ext,
    output logic              strobe_n,
    output logic [PHASE_W-1:0] phase,
    output logic              cycle_start,
    output logic              half_sel
);
    phase_t phase_nxt;
    phase_t phase_cur;
    logic   ext_nxt;

    fetch_phase_gen u_tim (
        .clk         (clk_osc),
        .rst         (rst),
        .phase_nxt   (phase_nxt),
        .phase       (phase_cur),
        .cycle_start (cycle_start),
        .half_sel    (half_sel)
    );

    fetch_source_sel #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_src (
        .clk       (clk_osc),
        .rst       (rst),
        .ext_pin   (ext_access),
        .sec_lock  (sec_lock),
        .pc        (pc),
        .mem_size  (mem_size),
        .phase_nxt (phase_nxt),
        .ext_nxt   (ext_nxt),
        .fetch_ext (fetch_ext)
    );

    fetch_strobe_gen u_stb (
        .clk         (clk_osc),
        .rst         (rst),
        .phase_nxt   (phase_nxt),
        .ext_nxt     (ext_nxt),
        .xdata_cycle (xdata_cycle),
        .phase       (phase_cur),
        .fetch_ext   (fetch_ext),
        .strobe_n    (strobe_n)
    );

    assign phase = phase_cur;

    // R2
    half_mark_chk: assert property (@(posedge clk_osc) disable iff (rst)
        half_sel == (phase_cur >= phase_t'(HALF_LEN)));
endmodule

// File: tb/fetch_ctrl_test.sv
module fetch_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_access = 1'b1;
    logic        sec_lock = 1'b0;
    logic [15:0] pc = '0;
    logic [1:0]  mem_size = '0;
    logic        xdata_cycle = 1'b0;
    logic        fetch_ext, strobe_n, cycle_start, half_sel;
    logic [3:0]  phase;

    int n_chk = 0;
    int n_fail = 0;
    logic latched_pin = 1'b1;
    logic done = 1'b0;

    typedef struct packed {
        logic [3:0] ph;
        logic       sn;
        logic       fe;
        logic       cs;
        logic       hs;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_ctrl uut (
        .clk_osc     (clk),
        .rst         (rst),
        .ext_access  (ext_access),
        .sec_lock    (sec_lock),
        .pc          (pc),
        .mem_size    (mem_size),
        .xdata_cycle (xdata_cycle),
        .fetch_ext   (fetch_ext),
        .strobe_n    (strobe_n),
        .phase       (phase),
        .cycle_start (cycle_start),
        .half_sel    (half_sel)
    );

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic model_ext(input logic [15:0] a, input logic [1:0] sz, input logic eff);
        logic [16:0] lim;
        lim = (17'd1 << (13 + int'(sz))) - 17'd1;
        return !eff || ({1'b0, a} > lim);
    endfunction

    function automatic logic model_win(input int k);
        int off;
        off = k % 6;
        return off >= 1 && off <= 4;
    endfunction

    // monitor: pop expectations and compare with outputs between edges
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(phase == e.ph,       {t, " R2 phase"},      int'(phase),       int'(e.ph));
            check(cycle_start == e.cs, {t, " R2 cycle_start"}, int'(cycle_start), int'(e.cs));
            check(half_sel == e.hs,    {t, " R2 half_sel"},   int'(half_sel),    int'(e.hs));
            check(fetch_ext == e.fe,   {t, " fetch_ext"},     int'(fetch_ext),   int'(e.fe));
            check(strobe_n == e.sn,    {t, " strobe_n"},      int'(strobe_n),    int'(e.sn));
        end
    end

    // enter at the negedge showing phase 11 (or right after do_reset)
    task automatic run_cycle(input logic [15:0] pc0, input logic [15:0] pc1,
                             input logic [1:0] sz, input logic pin,
                             input logic xd, input string tag);
        logic eff, e0, e1;
        #1;
        ext_access  = pin;
        mem_size    = sz;
        pc          = pc0;
        xdata_cycle = xd;
        eff = sec_lock ? latched_pin : pin;
        e0 = model_ext(pc0, sz, eff);
        e1 = model_ext(pc1, sz, eff);
        for (int k = 0; k < 12; k++) begin
            exp_t e;
            e.ph = 4'(k);
            e.fe = (k < 6) ? e0 : e1;
            e.sn = !(e.fe && !xd && model_win(k));
            e.cs = (k == 0);
            e.hs = (k >= 6);
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 5) begin
                pc          = pc1;
                xdata_cycle = !xd;
            end
        end
    endtask

    task automatic do_reset(input logic pin, input logic lock);
        #1;
        rst         = 1'b1;
        ext_access  = pin;
        sec_lock    = lock;
        pc          = '0;
        xdata_cycle = 1'b0;
        latched_pin = pin;
        repeat (3) @(negedge clk);
        check(strobe_n == 1'b1,    "R1 strobe_n in reset",    int'(strobe_n),    1);
        check(phase == 4'd0,       "R1 phase in reset",       int'(phase),       0);
        check(cycle_start == 1'b1, "R1 cycle_start in reset", int'(cycle_start), 1);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k < 12; k++) begin
            @(negedge clk);
            check(phase == 4'(k), "R2 phase after release", int'(phase), k);
        end
    endtask

    initial begin
        do_reset(1'b1, 1'b0);
        run_cycle(16'h0100, 16'h0102, 2'd0, 1'b1, 1'b0, "R5 internal low addr");
        run_cycle(16'h1FFF, 16'h2000, 2'd0, 1'b1, 1'b0, "R7 8K edge");
        run_cycle(16'h2000, 16'h1FFF, 2'd0, 1'b1, 1'b0, "R7 8K back");
        run_cycle(16'h3FFF, 16'h4000, 2'd1, 1'b1, 1'b0, "R7 16K edge");
        run_cycle(16'h7FFF, 16'h8000, 2'd2, 1'b1, 1'b0, "R7 32K edge");
        run_cycle(16'hFFFF, 16'h8000, 2'd3, 1'b1, 1'b0, "R8 64K internal");
        run_cycle(16'h0000, 16'h0010, 2'd0, 1'b0, 1'b0, "R6 pin low R3 pulses");
        run_cycle(16'h0020, 16'h0021, 2'd0, 1'b0, 1'b1, "R4 xdata suppress");
        run_cycle(16'h0022, 16'h0023, 2'd0, 1'b0, 1'b0, "R3 after xdata");
        run_cycle(16'h1000, 16'h9000, 2'd0, 1'b1, 1'b0, "R10 halves");
        run_cycle(16'h9000, 16'h0004, 2'd2, 1'b1, 1'b1, "R10 R4 mixed");
        do_reset(1'b1, 1'b1);
        run_cycle(16'h0000, 16'h0005, 2'd0, 1'b0, 1'b0, "R9 locked high");
        do_reset(1'b0, 1'b1);
        run_cycle(16'h0000, 16'h0005, 2'd0, 1'b1, 1'b0, "R9 locked low");
        do_reset(1'b1, 1'b0);
        run_cycle(16'h0000, 16'h0005, 2'd0, 1'b0, 1'b0, "R9 unlocked live pin");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule